// File: doc/BRIEF.md
# Serial Register Slave with Byte Writes and Pipelined Reads

This block is a serial slave for a four-wire bus (chip select, clock, data in, data out) in SPI mode 3, with 16 bits in each frame. Each frame asks to write one byte of a bank of 16-bit registers, or asks to read a whole register. A read comes back on the data output during the frame after the request, so a master that sends read requests back to back gets a continuous stream of data. The bus pins pass through two-flop synchronizers into the system clock. The system clock must therefore run at least eight times faster than the serial clock.

The bank holds 64 words. A parameter mask marks which words exist and a second mask marks which of them the bus may write. The remaining existing words are filled from the core side through a parallel port, and that port can also read any word. Two words have fixed roles. The status word holds a sticky framing-error flag, set when chip select goes high after a clock count that is not a multiple of 16. The command word turns each bit written to it into a single-cycle request pulse toward the core, and its bits then clear on their own.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is 16 bits, MSB first, with data in sampled on serial clock rising edges. Bit 15 selects the operation (1 = write, 0 = read). Bits 14:8 carry the byte address and bits 7:0 the write byte. A frame finishes on its 16th rising edge.
- R2: A 16-bit register uses byte address 2w for bits 7:0 and 2w+1 for bits 15:8. A write to either address changes only that byte of word w.
- R3: After a read frame, the next frame shifts out on the data output the whole 16-bit word selected by address bits 6:1, MSB first. Bits 7:0 of a read frame are ignored. The frame after a write, and the first frame after reset, shifts out 0x0000.
- R4: The data output changes only after serial clock falling edges and stays stable while the serial clock is high.
- R5: The data output is high-impedance whenever chip select is high.
- R6: Bit 0 of the status word (byte address 0x3C) becomes 1 when chip select rises after a clock count that is not a multiple of 16. It stays 1 until reset. The other status bits read 0.
- R7: Writing byte 0x3E or 0x3F places the written bits on the matching half of the command pulse output for exactly one clock cycle after the frame ends, and zero after that. Reading the command word returns 0x0000.
- R8: A bus write to a word that is read-only or that does not exist has no effect. A read of a word that does not exist returns 0x0000. By default the existing words are 0 to 15, 30 and 31, and the bus-writable words are 1 to 3, 8 to 15 and 31.
- R9: The core port returns the word at the core address one clock after it is presented. A core write replaces a read-only data word (one that exists, is not bus-writable, and is not the status or command word), and later bus reads see the new value.
- R10: After reset every stored word, the error flag and the command pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, high-impedance when deselected |
| core_addr | input | 6 | Core port word address |
| core_we | input | 1 | Core write enable |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data, registered |
| cmd_pulse | output | 16 | Single-cycle command requests |

## Verification
Write-then-read sequences to even and odd addresses of the same word show whether byte lanes are kept apart. A read frame sent with nonzero data bits shows that the data field is ignored. Chains of reads mixed with writes check the one-frame pipeline, including the zero returned after a write. Writes to read-only and missing words, a core write followed by a bus read, command frames that target either half of the command word, and a truncated nine-clock frame followed by a status read cover the side paths. The bench checks each of these against its own model of the bank.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int FRAME_W = 16;
  localparam int BADDR_W = 7;
  localparam int WADDR_W = BADDR_W - 1;
  localparam int WORDS   = 1 << WADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic                wr;
    logic [BADDR_W-1:0]  baddr;
    logic [7:0]          wbyte;
  } spi_frame_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= INIT;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_data,
  output logic               frame_done,
  output spi_frame_t         frame,
  output logic               err_flag,
  output logic               sclk_fall,
  output logic               miso_q
);
  logic               sclk_d, cs_d;
  logic               sclk_rise, cs_rise;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] rx_sh;
  logic [FRAME_W-1:0] tx_sh;

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  assign cs_rise   = cs_n_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  // receive side: count edges, assemble the word
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      frame_done <= 1'b0;
      frame      <= '0;
    end else begin
      frame_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sh   <= {rx_sh[FRAME_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(FRAME_W-1)) begin
          frame_done <= 1'b1;
          frame      <= spi_frame_t'({rx_sh, mosi_s});
        end
      end
    end
  end

  // sticky framing error
  always_ff @(posedge clk) begin
    if (rst) err_flag <= 1'b0;
    else if (cs_rise && bit_cnt != '0) err_flag <= 1'b1;
  end

  // transmit side: load after a frame, shift on falling edges
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (load) begin
      tx_sh <= load_data;
    end else if (sclk_fall) begin
      miso_q <= tx_sh[FRAME_W-1];
      tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank
  import spi_rb_pkg::*;
#(
  parameter logic [WORDS-1:0] VALID_MASK = '1,
  parameter logic [WORDS-1:0] WR_MASK    = '0,
  parameter int               STAT_WORD  = 30,
  parameter int               CMD_WORD   = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_we,
  input  logic [BADDR_W-1:0] spi_baddr,
  input  logic [7:0]         spi_wbyte,
  input  logic               spi_re,
  input  logic [WADDR_W-1:0] spi_rword,
  output logic [FRAME_W-1:0] spi_rdata,
  input  logic [WADDR_W-1:0] core_addr,
  input  logic               core_we,
  input  logic [FRAME_W-1:0] core_wdata,
  output logic [FRAME_W-1:0] core_rdata,
  input  logic               err_flag,
  output logic [FRAME_W-1:0] cmd_pulse
);
  logic [FRAME_W-1:0] mem [WORDS];
  logic [WADDR_W-1:0] spi_wword;
  logic               spi_hi;

  assign spi_wword = spi_baddr[BADDR_W-1:1];
  assign spi_hi    = spi_baddr[0];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (WR_MASK[g] && VALID_MASK[g] && g != CMD_WORD && g != STAT_WORD) begin : g_bus
      always_ff @(posedge clk) begin
        if (rst) mem[g] <= '0;
        else if (spi_we && spi_wword == WADDR_W'(g)) begin
          if (spi_hi) mem[g][15:8] <= spi_wbyte;
          else        mem[g][7:0]  <= spi_wbyte;
        end
      end
    end else if (VALID_MASK[g] && g != CMD_WORD && g != STAT_WORD) begin : g_core
      always_ff @(posedge clk) begin
        if (rst) mem[g] <= '0;
        else if (core_we && core_addr == WADDR_W'(g)) mem[g] <= core_wdata;
      end
    end else begin : g_none
      assign mem[g] = '0;
    end
  end

  // command word: bits live for one cycle
  always_ff @(posedge clk) begin
    if (rst) cmd_pulse <= '0;
    else if (spi_we && spi_wword == WADDR_W'(CMD_WORD))
      cmd_pulse <= spi_hi ? {spi_wbyte, 8'h00} : {8'h00, spi_wbyte};
    else cmd_pulse <= '0;
  end

  function automatic logic [FRAME_W-1:0] read_word(input logic [WADDR_W-1:0] w);
    if (!VALID_MASK[w])                   return '0;
    else if (w == WADDR_W'(STAT_WORD))    return {{(FRAME_W-1){1'b0}}, err_flag};
    else if (w == WADDR_W'(CMD_WORD))     return '0;
    else                                  return mem[w];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_rdata  <= '0;
      core_rdata <= '0;
    end else begin
      if (spi_re) spi_rdata <= read_word(spi_rword);
      core_rdata <= read_word(core_addr);
    end
  end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [WORDS-1:0] VALID_MASK  = 64'h0000_0000_C000_FFFF,
  parameter logic [WORDS-1:0] WR_MASK     = 64'h0000_0000_8000_FF0E,
  parameter int               STAT_WORD   = 30,
  parameter int               CMD_WORD    = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_cs_n,
  input  logic               spi_sclk,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [WADDR_W-1:0] core_addr,
  input  logic               core_we,
  input  logic [FRAME_W-1:0] core_wdata,
  output logic [FRAME_W-1:0] core_rdata,
  output logic [FRAME_W-1:0] cmd_pulse
);
  logic               sclk_s, cs_n_s, mosi_s;
  logic               frame_done, err_flag, sclk_fall, miso_q;
  spi_frame_t         frame;
  logic               load_q, rd_q;
  logic [FRAME_W-1:0] rd_data;
  logic               spi_wr;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_cs_n, spi_mosi}),
    .q   ({sclk_s, cs_n_s, mosi_s})
  );

  spi_rb_frame u_frame (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (sclk_s),
    .cs_n_s     (cs_n_s),
    .mosi_s     (mosi_s),
    .load       (load_q),
    .load_data  (rd_q ? rd_data : '0),
    .frame_done (frame_done),
    .frame      (frame),
    .err_flag   (err_flag),
    .sclk_fall  (sclk_fall),
    .miso_q     (miso_q)
  );

  assign spi_wr = frame_done & frame.wr;

  spi_rb_bank #(
    .VALID_MASK (VALID_MASK),
    .WR_MASK    (WR_MASK),
    .STAT_WORD  (STAT_WORD),
    .CMD_WORD   (CMD_WORD)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .spi_we     (spi_wr),
    .spi_baddr  (frame.baddr),
    .spi_wbyte  (frame.wbyte),
    .spi_re     (frame_done & ~frame.wr),
    .spi_rword  (frame.baddr[BADDR_W-1:1]),
    .spi_rdata  (rd_data),
    .core_addr  (core_addr),
    .core_we    (core_we),
    .core_wdata (core_wdata),
    .core_rdata (core_rdata),
    .err_flag   (err_flag),
    .cmd_pulse  (cmd_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      load_q <= frame_done;
      if (frame_done) rd_q <= ~frame.wr;
    end
  end

  assign spi_miso = spi_cs_n ? 1'bz : miso_q;
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker (
  input logic        clk,
  input logic        rst,
  input logic        frame_done,
  input logic        sclk_fall,
  input logic        miso_q,
  input logic        spi_wr,
  input logic        err_flag,
  input logic [15:0] cmd_pulse
);
  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R1
  AST_DOUT_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso_q) |-> $past(sclk_fall)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R6
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse != 16'h0) |=> (cmd_pulse == 16'h0)); // R7
  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse != 16'h0) |-> $past(spi_wr)); // R7
endmodule

bind spi_regbank_slave spi_rb_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_done (frame_done),
  .sclk_fall  (sclk_fall),
  .miso_q     (miso_q),
  .spi_wr     (spi_wr),
  .err_flag   (err_flag),
  .cmd_pulse  (cmd_pulse)
);

// File: tb/tb_spi_regbank_slave.sv
module tb_spi_regbank_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam int GAP  = 6;
  localparam logic [63:0] VALID = 64'h0000_0000_C000_FFFF;
  localparam logic [63:0] WRM   = 64'h0000_0000_8000_FF0E;

  logic clk = 0, rst = 1;
  logic spi_cs_n = 1, spi_sclk = 1, spi_mosi = 0;
  wire  spi_miso;
  logic [5:0]  core_addr = 0;
  logic        core_we = 0;
  logic [15:0] core_wdata = 0;
  logic [15:0] core_rdata, cmd_pulse;

  spi_regbank_slave dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .core_addr(core_addr),
    .core_we(core_we), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .cmd_pulse(cmd_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$], got_q[$];
  string       tag_q[$];
  logic [15:0] model [64];
  logic        err_m = 0;
  logic [15:0] pending = 0;
  bit          skip_next = 0;
  int          pulse_cnt = 0;
  logic [15:0] pulse_acc = 0;

  task automatic chk(input string r, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [6:0] ba);
    int w = int'(ba[6:1]);
    if (!VALID[w]) return 16'h0;
    if (w == 30) return {15'h0, err_m};
    if (w == 31) return 16'h0;
    return model[w];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, g, e);
    end
  end

  always @(negedge clk) begin
    if (!rst && cmd_pulse != 16'h0) begin
      pulse_cnt++;
      pulse_acc |= cmd_pulse;
    end
  end

  // driver: one frame of nbits clocks, expected DOUT pushed before it runs
  task automatic spi_frame(input logic [15:0] tx, input int nbits, input string tag);
    logic [15:0] rx = 0;
    logic        h;
    bit          stable_ok = 1;
    bit          check_rx = (nbits == 16) && !skip_next;
    if (check_rx) begin exp_q.push_back(pending); tag_q.push_back(tag); end
    spi_cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 0; spi_mosi = tx[15-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[14:0], spi_miso};
      spi_sclk = 1;
      @(negedge clk); h = spi_miso;
      repeat (HALF-1) @(negedge clk);
      if (spi_miso !== h) stable_ok = 0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1;
    repeat (GAP) @(negedge clk);
    if (check_rx) got_q.push_back(rx);
    chk("R4 DOUT stable while SCLK high", {15'h0, stable_ok}, 16'h1);
    if (nbits == 16) begin
      skip_next = 0;
      if (tx[15]) begin
        int w = int'(tx[14:9]);
        if (WRM[w] && VALID[w] && w != 31 && w != 30) begin
          if (tx[8]) model[w][15:8] = tx[7:0];
          else       model[w][7:0]  = tx[7:0];
        end
        pending = 16'h0;
      end else pending = mread(tx[14:8]);
    end else begin
      if (nbits % 16 != 0) err_m = 1;
      skip_next = 1;
    end
  endtask

  task automatic core_write(input logic [5:0] a, input logic [15:0] d);
    core_addr = a; core_wdata = d; core_we = 1;
    @(negedge clk);
    core_we = 0;
    if (VALID[a] && !WRM[a] && a != 30 && a != 31) model[a] = d;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 / R5 reset state
    chk("R5 DOUT high-z while deselected", {15'h0, spi_miso === 1'bz}, 16'h1);
    chk("R10 command pulses zero", cmd_pulse, 16'h0);
    core_addr = 6'd1; @(negedge clk);
    chk("R10 stored word zero", core_rdata, 16'h0);

    // R1 R2 R3 byte writes and pipelined reads
    spi_frame(16'h8234, 16, "R3 first frame after reset");
    spi_frame(16'h8312, 16, "R3 after write");
    spi_frame(16'h0200, 16, "R3 after write");
    spi_frame(16'h0300, 16, "R2 R3 word1 via even address");
    spi_frame(16'h04FF, 16, "R2 R3 word1 via odd address");
    spi_frame(16'h84AB, 16, "R3 read data bits ignored");
    spi_frame(16'h0400, 16, "R3 after write");
    spi_frame(16'h8556, 16, "R2 low byte only");
    spi_frame(16'h0400, 16, "R3 after write");
    spi_frame(16'h1E00, 16, "R2 both bytes");
    spi_frame(16'h1600, 16, "R1 word15 zero");

    // R9 core port
    core_addr = 6'd1; @(negedge clk);
    chk("R9 core read of bus-written word", core_rdata, 16'h1234);
    core_write(6'd5, 16'hA5C3);
    core_addr = 6'd5; @(negedge clk);
    chk("R9 core read after core write", core_rdata, 16'hA5C3);
    spi_frame(16'h0A00, 16, "R1 previous read");
    spi_frame(16'h8A11, 16, "R9 bus sees core write");
    // R8 ignored writes, reserved reads
    spi_frame(16'h0B00, 16, "R3 after write");
    spi_frame(16'hA8FF, 16, "R8 read-only word unchanged");
    spi_frame(16'h2800, 16, "R3 after write");
    spi_frame(16'h0200, 16, "R8 reserved word reads zero");

    // R7 command pulses
    pulse_cnt = 0; pulse_acc = 0;
    spi_frame(16'hBF08, 16, "R2 word1 readback");
    chk("R7 high-half pulse count", 16'(pulse_cnt), 16'd1);
    chk("R7 high-half pulse value", pulse_acc, 16'h0800);
    pulse_cnt = 0; pulse_acc = 0;
    spi_frame(16'hBE01, 16, "R3 after write");
    chk("R7 low-half pulse count", 16'(pulse_cnt), 16'd1);
    chk("R7 low-half pulse value", pulse_acc, 16'h0001);
    spi_frame(16'h3E00, 16, "R3 after write");
    spi_frame(16'h3C00, 16, "R7 command word reads zero");

    // R6 framing error
    spi_frame(16'h0000, 16, "R6 status clear before error");
    spi_frame(16'h0200, 9, "partial");
    spi_frame(16'h3C00, 16, "unchecked");
    spi_frame(16'h0000, 16, "R6 error flag set");
    spi_frame(16'h3C00, 16, "R1 word0 zero");
    spi_frame(16'h0000, 16, "R6 error flag sticky");

    repeat (4) @(negedge clk);
    chk("R5 DOUT high-z after frames", {15'h0, spi_miso === 1'bz}, 16'h1);
    chk("R1 scoreboard drained", 16'(exp_q.size()), 16'd0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule